// File: doc/BRIEF.md
# Scaled System-Time Counter

This block keeps a free-running 64-bit system time as a fixed-point quantity. On every reference-oscillator tick it adds a programmable increment, so the value only becomes nanoseconds after a right shift by a number of bits that depends on the link speed. The oscillator period changes with link speed. The block publishes the matching shift and tick period, so that software can convert raw counts into time.

Two increment formats exist. Wide mode keeps a 31-bit increment. Narrow mode keeps a 24-bit increment, and its register image carries a period field set to one. When the link speed or the format changes, the increment register reloads the default for that setting. The accumulated count is kept. Software reads the count through a small register port. Reading the low word freezes the high word in a shadow register, so the 64-bit value put together from the two reads is coherent.

Top module: `scaled_time_counter`

## Requirements
- R1: After reset the count is zero, the increment register reads 0x66666666, `ns_shift` is 28 and `osc_period_ps` is 6400.
- R2: On each clock edge with `tick` high, the count grows by the effective increment, modulo 2^64. Without `tick` the count holds.
- R3: In wide mode the `link_speed` codes map as follows: 0 (10G) and 1 (no link) give increment 0x66666666, shift 28 and period 6400 ps; 2 (1G) gives 0x40000000, shift 24 and 64000 ps; 3 (100M) gives 0x50000000, shift 21 and 640000 ps.
- R4: In narrow mode (`narrow_mode`=1) the default increment is the wide default shifted right by 7, and the shift is 7 less. The increment register then reads back with bit 24 set to 1 and the increment in bits 23:0.
- R5: A change of `link_speed` or `narrow_mode` reloads the default increment on the edge where the change is seen. `ns_shift` and `osc_period_ps` follow on that same edge. The count is not altered.
- R6: A write to address 0 stores bits 30:0 in wide mode, where bit 31 is ignored and reads back as 0. In narrow mode it stores bits 23:0 and ignores bits 31:24. Writes to addresses 1 to 3 have no effect.
- R7: A tick on the same edge as an increment write still adds the old increment. The new value applies from the next tick on, and the count is not disturbed.
- R8: A read of address 1 returns the count as it stood before any tick on that same edge, and copies bits 63:32 into a shadow register. A read of address 2 returns the shadow, even when ticks have happened since.
- R9: Read data appears on the cycle after `reg_rd`, with `reg_rvalid` high for exactly that cycle. Address 3 reads as 0.
- R10: When a speed or format change and an increment write fall on the same edge, the reload of the default wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference-oscillator tick, one cycle wide |
| link_speed | input | 2 | 0 = 10G, 1 = no link, 2 = 1G, 3 = 100M |
| narrow_mode | input | 1 | 1 selects the 24-bit increment format |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | 0 = increment, 1 = count low, 2 = count high (shadow), 3 = reads zero |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response strobe |
| ns_shift | output | 5 | Right shift that turns the count into nanoseconds |
| osc_period_ps | output | 20 | Tick period for the current link speed, in picoseconds |

## Verification
The collisions of interest are a tick on the same edge as an increment write, and a tick on the same edge as a low-word read. The bench forces each one by asserting `tick` together with the register strobe in one driver step. Its reference model advances the count with the increment in force before the edge, and it takes the snapshot from the count before the tick. The outcome is judged through later reads of the count and of the shadowed high word, after further ticks. The same kind of step also combines a speed change with a write, to confirm that the reload wins.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int STC_CNT_W    = 64;
  localparam int STC_DATA_W   = 32;
  localparam int STC_WIDE_W   = 31;
  localparam int STC_NAR_W    = 24;
  localparam int STC_DROP     = 7;
  localparam int STC_SHIFT_W  = 5;
  localparam int STC_PER_W    = 20;
  localparam logic [STC_WIDE_W-1:0] STC_RST_INC = 31'h6666_6666;

  typedef struct packed {
    logic [STC_WIDE_W-1:0]  inc;
    logic [STC_SHIFT_W-1:0] shift;
    logic [STC_PER_W-1:0]   period_ps;
  } stc_dflt_t;

  function automatic stc_dflt_t stc_lookup(input logic [1:0] spd, input logic narrow);
    stc_dflt_t d;
    logic [31:0] base;
    logic [STC_SHIFT_W-1:0] sh;
    logic [STC_PER_W-1:0] per;
    case (spd)
      2'd2:    begin base = 32'h4000_0000; sh = 5'd24; per = 20'd64000;  end
      2'd3:    begin base = 32'h5000_0000; sh = 5'd21; per = 20'd640000; end
      default: begin base = 32'h6666_6666; sh = 5'd28; per = 20'd6400;   end
    endcase
    d.inc       = narrow ? STC_WIDE_W'(base >> STC_DROP) : base[STC_WIDE_W-1:0];
    d.shift     = narrow ? sh - STC_SHIFT_W'(STC_DROP) : sh;
    d.period_ps = per;
    return d;
  endfunction
endpackage

// File: rtl/stc_defaults.sv
module stc_defaults
  import stc_pkg::*;
(
  input  logic [1:0]             spd,
  input  logic                   narrow,
  output logic [STC_WIDE_W-1:0]  dflt_inc,
  output logic [STC_SHIFT_W-1:0] dflt_shift,
  output logic [STC_PER_W-1:0]   dflt_period
);
  stc_dflt_t d;
  always_comb begin
    d           = stc_lookup(spd, narrow);
    dflt_inc    = d.inc;
    dflt_shift  = d.shift;
    dflt_period = d.period_ps;
  end
endmodule

// File: rtl/stc_incr_reg.sv
module stc_incr_reg
  import stc_pkg::*;
#(
  parameter int INC_W  = STC_WIDE_W,
  parameter int NAR_W  = STC_NAR_W,
  parameter int DATA_W = STC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_spd,
  input  logic              cfg_narrow,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [INC_W-1:0]  dflt_inc,
  output logic [INC_W-1:0]  inc_q,
  output logic [1:0]        spd_q,
  output logic              narrow_q,
  output logic              reload
);
  logic [INC_W-1:0] inc_d;
  logic             inc_en;

  always_comb begin
    reload = (cfg_spd != spd_q) || (cfg_narrow != narrow_q);
    inc_en = reload || wr_en;
    inc_d  = inc_q;
    if (reload)
      inc_d = dflt_inc;
    else if (wr_en)
      inc_d = narrow_q ? INC_W'(wdata[NAR_W-1:0]) : wdata[INC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_q    <= STC_RST_INC;
      spd_q    <= 2'd0;
      narrow_q <= 1'b0;
    end else begin
      if (inc_en) inc_q <= inc_d;
      spd_q    <= cfg_spd;
      narrow_q <= cfg_narrow;
    end
  end
endmodule

// File: rtl/stc_accum.sv
module stc_accum
  import stc_pkg::*;
#(
  parameter int CNT_W = STC_CNT_W,
  parameter int INC_W = STC_WIDE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [INC_W-1:0] inc_eff,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb cnt_d = cnt_q + CNT_W'(inc_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/stc_readout.sv
module stc_readout
  import stc_pkg::*;
#(
  parameter int CNT_W  = STC_CNT_W,
  parameter int DATA_W = STC_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] inc_view,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] shadow_q
);
  localparam int HI_W = CNT_W - DATA_W;
  logic [DATA_W-1:0] rdata_d;
  logic              snap_en;

  always_comb begin
    snap_en = rd_en && (addr == 2'd1);
    case (addr)
      2'd0:    rdata_d = inc_view;
      2'd1:    rdata_d = cnt[DATA_W-1:0];
      2'd2:    rdata_d = shadow_q;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rvalid   <= 1'b0;
      shadow_q <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en)   rdata    <= rdata_d;
      if (snap_en) shadow_q <= DATA_W'(cnt[CNT_W-1 -: HI_W]);
    end
  end
endmodule

// File: rtl/scaled_time_counter.sv
module scaled_time_counter
  import stc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [1:0]             link_speed,
  input  logic                   narrow_mode,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [1:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic                   reg_rvalid,
  output logic [4:0]             ns_shift,
  output logic [19:0]            osc_period_ps
);
  logic [STC_WIDE_W-1:0]  new_inc;
  logic [STC_SHIFT_W-1:0] new_shift;
  logic [STC_PER_W-1:0]   new_period;
  logic [STC_WIDE_W-1:0]  inc_q;
  logic [STC_WIDE_W-1:0]  inc_eff;
  logic [1:0]             spd_q;
  logic                   narrow_q;
  logic                   reload;
  logic                   inc_wr;
  logic [STC_CNT_W-1:0]   cnt_q;
  logic [STC_DATA_W-1:0]  inc_view;
  logic [STC_DATA_W-1:0]  shadow_q;
  logic [STC_WIDE_W-1:0]  unused_inc;

  // defaults for the requested setting feed the reload path
  stc_defaults u_dflt_req (
    .spd(link_speed), .narrow(narrow_mode),
    .dflt_inc(new_inc), .dflt_shift(new_shift), .dflt_period(new_period)
  );

  // defaults for the setting in force drive the published shift and period
  stc_defaults u_dflt_cur (
    .spd(spd_q), .narrow(narrow_q),
    .dflt_inc(unused_inc), .dflt_shift(ns_shift), .dflt_period(osc_period_ps)
  );

  always_comb inc_wr = reg_wr && (reg_addr == 2'd0);

  stc_incr_reg u_inc (
    .clk(clk), .rst_n(rst_n),
    .cfg_spd(link_speed), .cfg_narrow(narrow_mode),
    .wr_en(inc_wr), .wdata(reg_wdata), .dflt_inc(new_inc),
    .inc_q(inc_q), .spd_q(spd_q), .narrow_q(narrow_q), .reload(reload)
  );

  always_comb begin
    if (narrow_q) begin
      inc_eff  = STC_WIDE_W'(inc_q[STC_NAR_W-1:0]);
      inc_view = {{(STC_DATA_W-STC_NAR_W-1){1'b0}}, 1'b1, inc_q[STC_NAR_W-1:0]};
    end else begin
      inc_eff  = inc_q;
      inc_view = {{(STC_DATA_W-STC_WIDE_W){1'b0}}, inc_q};
    end
  end

  stc_accum u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .inc_eff(inc_eff), .cnt_q(cnt_q)
  );

  stc_readout u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .addr(reg_addr),
    .cnt(cnt_q), .inc_view(inc_view),
    .rdata(reg_rdata), .rvalid(reg_rvalid), .shadow_q(shadow_q)
  );
endmodule

// File: rtl/stc_checker.sv
module stc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        reg_rd,
  input logic [1:0]  reg_addr,
  input logic        reg_rvalid,
  input logic [63:0] cnt_q,
  input logic [30:0] inc_eff,
  input logic [31:0] shadow_q,
  input logic [4:0]  ns_shift,
  input logic [19:0] osc_period_ps
);
  // R9
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> reg_rvalid);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n) !reg_rd |=> !reg_rvalid);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(cnt_q));
  // R2
  add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(cnt_q) + 64'($past(inc_eff)));
  // R8
  snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd1) |=> shadow_q == $past(cnt_q[63:32]));
  // R3
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_period_ps == 20'd6400) |-> (ns_shift == 5'd28 || ns_shift == 5'd21));
endmodule

bind scaled_time_counter stc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rvalid(reg_rvalid), .cnt_q(cnt_q), .inc_eff(inc_eff), .shadow_q(shadow_q),
  .ns_shift(ns_shift), .osc_period_ps(osc_period_ps)
);

// File: tb/sim_scaled_time_counter.sv
module sim_scaled_time_counter;
  localparam time CLK_PERIOD = 10ns;

  logic        clk, rst_n, tick, narrow_mode, reg_wr, reg_rd;
  logic [1:0]  link_speed, reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic [4:0]  ns_shift;
  logic [19:0] osc_period_ps;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [63:0] m_cnt;
  logic [30:0] m_inc;
  logic [31:0] m_shadow;
  logic [1:0]  m_spd, cur_spd;
  logic        m_nar, cur_nar;

  scaled_time_counter u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .link_speed(link_speed),
    .narrow_mode(narrow_mode), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .ns_shift(ns_shift), .osc_period_ps(osc_period_ps)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [30:0] ref_inc(input logic [1:0] s, input logic n);
    case (s)
      2'd2:    return n ? 31'h0080_0000 : 31'h4000_0000;
      2'd3:    return n ? 31'h00A0_0000 : 31'h5000_0000;
      default: return n ? 31'h00CC_CCCC : 31'h6666_6666;
    endcase
  endfunction

  function automatic logic [31:0] ref_view(input logic [30:0] v, input logic n);
    return n ? {8'h01, v[23:0]} : {1'b0, v};
  endfunction

  // driver: one cycle of stimulus, expected read data pushed to scoreboard
  task automatic step(input bit t, input bit w, input bit r, input logic [1:0] a,
                      input logic [31:0] d, input string tag);
    bit rl;
    @(posedge clk); #1;
    tick = t; reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    link_speed = cur_spd; narrow_mode = cur_nar;
    rl = (cur_spd != m_spd) || (cur_nar != m_nar);
    if (r) begin
      case (a)
        2'd0: exp_q.push_back(ref_view(m_inc, m_nar));
        2'd1: begin exp_q.push_back(m_cnt[31:0]); m_shadow = m_cnt[63:32]; end
        2'd2: exp_q.push_back(m_shadow);
        default: exp_q.push_back(32'h0);
      endcase
      tag_q.push_back(tag);
    end
    if (t) m_cnt = m_cnt + 64'(m_nar ? {7'b0, m_inc[23:0]} : m_inc);
    if (rl) begin
      m_inc = ref_inc(cur_spd, cur_nar); m_spd = cur_spd; m_nar = cur_nar;
    end else if (w && a == 2'd0) begin
      m_inc = m_nar ? {7'b0, d[23:0]} : d[30:0];
    end
  endtask

  task automatic idle(); step(0, 0, 0, 2'd0, 32'h0, ""); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) step(1, 0, 0, 2'd0, 32'h0, ""); endtask
  task automatic rd(input logic [1:0] a, input string tag); step(0, 0, 1, a, 32'h0, tag); endtask
  task automatic rd_cnt(input string tag); rd(2'd1, tag); rd(2'd2, tag); endtask

  task automatic chk_cfg(input logic [4:0] sh, input logic [19:0] per, input string tag);
    checks++;
    if (ns_shift !== sh || osc_period_ps !== per) begin
      errors++;
      $display("FAIL %s: shift/period actual %0d/%0d expected %0d/%0d", tag, ns_shift, osc_period_ps, sh, per);
    end
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic n);
    cur_spd = s; cur_nar = n; idle(); idle();
  endtask

  // monitor: compares every read response with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected response actual %h expected none", reg_rdata);
      end else begin
        logic [31:0] e; string tg;
        e = exp_q.pop_front(); tg = tag_q.pop_front();
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s: read data actual %h expected %h", tg, reg_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    link_speed = 0; narrow_mode = 0; cur_spd = 0; cur_nar = 0;
    m_cnt = 0; m_inc = 31'h6666_6666; m_shadow = 0; m_spd = 0; m_nar = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    idle();
    chk_cfg(5'd28, 20'd6400, "R1");
    rd(2'd0, "R1"); rd_cnt("R1");

    ticks(5); rd_cnt("R2");
    idle(); idle(); rd_cnt("R2 hold");

    step(0, 1, 0, 2'd0, 32'hFFFF_FFFF, "");
    rd(2'd0, "R6 wide bit31");
    ticks(7); rd_cnt("R2 carry");

    step(1, 1, 0, 2'd0, 32'h0000_0100, "");
    rd_cnt("R7 old inc"); ticks(3); rd_cnt("R7 new inc"); rd(2'd0, "R7");

    step(1, 0, 1, 2'd1, 32'h0, "R8 tick+read");
    ticks(4); rd(2'd2, "R8 shadow"); rd_cnt("R8");

    step(0, 1, 0, 2'd1, 32'hDEAD_BEEF, "");
    step(0, 1, 0, 2'd2, 32'hDEAD_BEEF, "");
    rd_cnt("R6 other addr"); rd(2'd0, "R6 other addr"); rd(2'd3, "R9 addr3");

    set_cfg(2'd2, 0); chk_cfg(5'd24, 20'd64000, "R3 1G");
    rd(2'd0, "R3 1G"); rd_cnt("R5 count kept");
    ticks(2); rd_cnt("R3 1G add");
    set_cfg(2'd3, 0); chk_cfg(5'd21, 20'd640000, "R3 100M"); rd(2'd0, "R3 100M");
    set_cfg(2'd1, 0); chk_cfg(5'd28, 20'd6400, "R3 nolink"); rd(2'd0, "R3 nolink");

    set_cfg(2'd0, 1); chk_cfg(5'd21, 20'd6400, "R4 10G"); rd(2'd0, "R4 10G");
    ticks(3); rd_cnt("R4 add");
    set_cfg(2'd2, 1); chk_cfg(5'd17, 20'd64000, "R4 1G"); rd(2'd0, "R4 1G");
    set_cfg(2'd3, 1); chk_cfg(5'd14, 20'd640000, "R4 100M"); rd(2'd0, "R4 100M");

    step(0, 1, 0, 2'd0, 32'hABCD_EF12, "");
    rd(2'd0, "R6 narrow"); ticks(2); rd_cnt("R6 narrow add");

    cur_spd = 2'd0; cur_nar = 0;
    step(1, 1, 0, 2'd0, 32'h0000_1234, "");
    rd(2'd0, "R10 reload wins"); rd_cnt("R10 count");
    idle(); chk_cfg(5'd28, 20'd6400, "R5 follow");

    idle(); idle(); idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: pending responses actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule